// File: doc/BRIEF.md
# Real-Time Clock with Field Alarm

This block keeps time of day as four chained counters: seconds, minutes, hours and day of week. A prescaler counts pulses of a reference tick input, and each time it wraps it advances the seconds counter by one. Carries ripple up the chain, so the hours counter rolls into the day of week, and the day of week runs from 1 to 7. The whole register set, meaning the counters and the alarm set points, counts either in plain binary or in packed BCD. A control bit selects which.

An alarm compares each time field with its own set point. Each field has its own enable bit. When every enabled field matches, a sticky alarm flag is raised, along with an interrupt if that is enabled. Software clears the flag and the interrupt by reading the control/status register. If the alarm fires while the system is asleep, a wake status bit is set, and this bit survives reset. The time and set-point registers can be written only while an unlock bit is set. Any write to the control register restarts the prescaler, so software can line up the seconds edge with another time source.

Register map (byte-wide data; a read returns data on the cycle after the read strobe):

| Address | Register |
|---|---|
| 0 | control/status |
| 1 | alarm enables |
| 2 to 5 | seconds, minutes, hours, day of week |
| 6 to 9 | set points, in the same field order |

Top module: `rtc_alarm_top`

## Requirements
- R1: The prescaler produces exactly one single-cycle seconds advance for every TICKS_PER_SEC reference tick pulses.
- R2: Any write to the control register (address 0) resets the prescaler. The next seconds advance then comes only after TICKS_PER_SEC further tick pulses.
- R3: In binary mode, seconds wrap 59→0 with a carry into minutes. Minutes wrap 59→0 with a carry into hours. Hours wrap 23→0 with a carry into day of week. Day of week wraps 7→1.
- R4: With the mode bit (control bit 1) set, all counters and set points are packed BCD. A low digit of 9 steps to 0 with a carry into the high digit. The wrap points are 0x59, 0x59, 0x23 and 0x07, and set points are compared in BCD.
- R5: The alarm flag (control bit 7) is set when every field enabled at address 1 equals its set point. It is evaluated only after a seconds advance or when the unlock bit goes from 1 to 0. With no field enabled, no alarm occurs.
- R6: The alarm enable register uses bit 0 for seconds, bit 1 for minutes, bit 2 for hours and bit 3 for day of week. Bits 7:4 read as zero. The register is writable at any time and resets to zero.
- R7: A read of address 0 clears the alarm flag and the interrupt. If a new alarm event happens in the same cycle, the flag stays set.
- R8: `irq_o` is high exactly while the alarm flag is set and the interrupt enable (control bit 2) is 1.
- R9: Writes to the time registers (2 to 5) and the set points (6 to 9) take effect only while the unlock bit (control bit 0) is 1. Otherwise they are ignored.
- R10: Wake status (control bit 5) is set by an alarm event while `sleep_i` is high. Reset leaves it unchanged, and a read of address 0 clears it.
- R11: After reset, the control register and the set points are 0 and the time reads 00:00:00 with day of week 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | Reference tick pulse, one cycle per tick |
| sleep_i | input | 1 | High while the system is in a sleep state |
| bus_addr | input | AW | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered, valid the cycle after `bus_rd` |
| irq_o | output | 1 | Alarm interrupt |

## Verification
The hardest case to reach from the ports is a status read that lands in the same cycle as a new alarm event. Tick-driven events are several register stages away from the bus. The bench instead uses the lock transition as the evaluation trigger: it writes the control register to lock it with a matching set point already loaded, then issues the status read on the very next cycle, which is the cycle the flag is being set. The wake bit's survival across reset is reached the same way, by raising `sleep_i` around a lock-triggered match and then pulsing reset.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  localparam int NFIELD  = 4;
  localparam int A_CTRL  = 0;
  localparam int A_AEN   = 1;
  localparam int A_TIME0 = 2;
  localparam int A_ALRM0 = 6;

  // encode a small binary number in the selected number system
  function automatic logic [7:0] enc_val(input logic [7:0] v, input logic bcd);
    logic [7:0] tens, ones;
    tens = v / 8'd10;
    ones = v % 8'd10;
    if (bcd) return {tens[3:0], ones[3:0]};
    return v;
  endfunction

  // advance a field value by one in the selected number system
  function automatic logic [7:0] step_val(input logic [7:0] v, input logic bcd);
    if (bcd && v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int TICKS = 32768
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic sync_i,
  output logic inc_o
);
  localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;

  logic [CW-1:0] cnt_q;
  logic          inc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      inc_q <= 1'b0;
    end else begin
      inc_q <= 1'b0;
      if (sync_i) begin
        cnt_q <= '0;
      end else if (tick_i) begin
        if (cnt_q == CW'(TICKS - 1)) begin
          cnt_q <= '0;
          inc_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign inc_o = inc_q;

  // R2: a control write leaves the prescaler restarted with no pending advance
  a_r2_sync_restart: assert property (@(posedge clk) disable iff (rst)
    $past(sync_i) |-> (cnt_q == '0 && !inc_o));

  // R1: every advance is a single-cycle pulse
  a_r1_single_pulse: assert property (@(posedge clk) disable iff (rst)
    (TICKS > 1 && inc_o) |=> !inc_o);
endmodule

// File: rtl/rtc_time_field.sv
module rtc_time_field #(
  parameter int MIN_V = 0,
  parameter int MAX_V = 59
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bcd_i,
  input  logic       inc_i,
  input  logic       load_i,
  input  logic [7:0] load_d,
  output logic [7:0] value_o,
  output logic       carry_o
);
  import rtc_alarm_pkg::*;

  logic [7:0] val_q;
  logic [7:0] max_enc;
  logic [7:0] min_enc;
  logic       at_max;

  always_comb begin
    max_enc = enc_val(8'(MAX_V), bcd_i);
    min_enc = enc_val(8'(MIN_V), bcd_i);
    at_max  = (val_q >= max_enc);
  end

  always_ff @(posedge clk) begin
    if (rst)         val_q <= 8'(MIN_V);
    else if (load_i) val_q <= load_d;
    else if (inc_i)  val_q <= at_max ? min_enc : step_val(val_q, bcd_i);
  end

  assign value_o = val_q;
  assign carry_o = inc_i & at_max;

  // R3: an advance from the top value lands on the bottom value
  a_r3_wrap_to_min: assert property (@(posedge clk) disable iff (rst)
    ($past(inc_i) && !$past(load_i) && $past(at_max)) |-> (val_q == 8'(MIN_V)));
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match #(
  parameter int NF = 4,
  parameter int DW = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NF-1:0]         en_i,
  input  logic [NF-1:0][DW-1:0] now_i,
  input  logic [NF-1:0][DW-1:0] set_i,
  input  logic                  eval_i,
  input  logic                  clr_i,
  input  logic                  sleep_i,
  output logic                  flag_o,
  output logic                  wake_o
);
  logic [NF-1:0] field_ok;
  logic          hit;
  logic          event_w;
  logic          flag_q;
  logic          wake_q = 1'b0;

  for (genvar i = 0; i < NF; i++) begin : g_cmp
    assign field_ok[i] = !en_i[i] || (now_i[i] == set_i[i]);
  end

  assign hit     = (|en_i) && (&field_ok);
  assign event_w = eval_i && hit;

  always_ff @(posedge clk) begin
    if (rst)          flag_q <= 1'b0;
    else if (event_w) flag_q <= 1'b1;
    else if (clr_i)   flag_q <= 1'b0;
  end

  // wake status is deliberately outside the reset domain
  always_ff @(posedge clk) begin
    if (event_w && sleep_i) wake_q <= 1'b1;
    else if (clr_i)         wake_q <= 1'b0;
  end

  assign flag_o = flag_q;
  assign wake_o = wake_q;

  // R5: the flag only rises after an evaluation moment
  a_r5_rise_needs_eval: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_o) |-> $past(eval_i));

  // R7: a status read with no competing event leaves the flag clear
  a_r7_read_clears: assert property (@(posedge clk) disable iff (rst)
    ($past(clr_i) && !$past(eval_i)) |-> !flag_o);

  // R10: wake only rises together with an alarm
  a_r10_wake_with_alarm: assert property (@(posedge clk) disable iff (rst)
    $rose(wake_o) |-> flag_o);
endmodule

// File: rtl/rtc_alarm_top.sv
module rtc_alarm_top #(
  parameter int TICKS_PER_SEC = 32768,
  parameter int AW            = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ref_tick,
  input  logic          sleep_i,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  output logic          irq_o
);
  import rtc_alarm_pkg::*;

  localparam int FMIN [NFIELD] = '{0, 0, 0, 1};
  localparam int FMAX [NFIELD] = '{59, 59, 23, 7};

  logic                    unlock_q, bcd_q, irqen_q;
  logic [NFIELD-1:0]       aen_q;
  logic [NFIELD-1:0][7:0]  alarm_q;
  logic [NFIELD-1:0][7:0]  now_w;
  logic [NFIELD:0]         inc_w;
  logic                    wr_ctrl, rd_ctrl, lock_evt, eval_q;
  logic                    flag_w, wake_w;
  logic [7:0]              rd_mux;
  logic [7:0]              rdata_q;

  assign wr_ctrl  = bus_wr && (bus_addr == AW'(A_CTRL));
  assign rd_ctrl  = bus_rd && (bus_addr == AW'(A_CTRL));
  assign lock_evt = wr_ctrl && unlock_q && !bus_wdata[0];

  rtc_prescaler #(.TICKS(TICKS_PER_SEC)) u_pre (
    .clk(clk), .rst(rst), .tick_i(ref_tick), .sync_i(wr_ctrl), .inc_o(inc_w[0])
  );

  for (genvar i = 0; i < NFIELD; i++) begin : g_field
    logic load_w;
    assign load_w = bus_wr && unlock_q && (bus_addr == AW'(A_TIME0 + i));
    rtc_time_field #(.MIN_V(FMIN[i]), .MAX_V(FMAX[i])) u_fld (
      .clk(clk), .rst(rst), .bcd_i(bcd_q), .inc_i(inc_w[i]),
      .load_i(load_w), .load_d(bus_wdata),
      .value_o(now_w[i]), .carry_o(inc_w[i+1])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      unlock_q <= 1'b0;
      bcd_q    <= 1'b0;
      irqen_q  <= 1'b0;
      aen_q    <= '0;
      eval_q   <= 1'b0;
    end else begin
      eval_q <= inc_w[0] || lock_evt;
      if (wr_ctrl) begin
        unlock_q <= bus_wdata[0];
        bcd_q    <= bus_wdata[1];
        irqen_q  <= bus_wdata[2];
      end
      if (bus_wr && bus_addr == AW'(A_AEN)) aen_q <= bus_wdata[NFIELD-1:0];
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NFIELD; i++) begin
      if (rst) alarm_q[i] <= '0;
      else if (bus_wr && unlock_q && bus_addr == AW'(A_ALRM0 + i)) alarm_q[i] <= bus_wdata;
    end
  end

  rtc_alarm_match #(.NF(NFIELD), .DW(8)) u_match (
    .clk(clk), .rst(rst), .en_i(aen_q), .now_i(now_w), .set_i(alarm_q),
    .eval_i(eval_q), .clr_i(rd_ctrl), .sleep_i(sleep_i),
    .flag_o(flag_w), .wake_o(wake_w)
  );

  always_comb begin
    rd_mux = '0;
    if (bus_addr == AW'(A_CTRL))
      rd_mux = {flag_w, 1'b0, wake_w, 2'b00, irqen_q, bcd_q, unlock_q};
    else if (bus_addr == AW'(A_AEN))
      rd_mux = {{(8-NFIELD){1'b0}}, aen_q};
    for (int i = 0; i < NFIELD; i++) begin
      if (bus_addr == AW'(A_TIME0 + i)) rd_mux = now_w[i];
      if (bus_addr == AW'(A_ALRM0 + i)) rd_mux = alarm_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_mux;
  end

  assign bus_rdata = rdata_q;
  assign irq_o     = flag_w && irqen_q;

  // R9: while locked and with no seconds advance, the time stays put
  a_r9_locked_hold: assert property (@(posedge clk) disable iff (rst)
    ($past(!unlock_q) && !$past(inc_w[0])) |-> $stable(now_w));
endmodule

// File: tb/rtc_alarm_top_bench.sv
module rtc_alarm_top_bench;
  localparam int TPS = 4;

  logic       clk = 1'b0, rst = 1'b1, ref_tick = 1'b0, sleep_i = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq_o;
  int         total = 0, bad = 0;
  logic       done = 1'b0;

  always #2 clk = ~clk;

  rtc_alarm_top #(.TICKS_PER_SEC(TPS), .AW(4)) u_rtc_alarm_top (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .sleep_i(sleep_i),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  // {bcd, start sec/min/hr/dow, expected after one second}
  localparam logic [71:0] VEC [8] = '{
    {8'h00, 32'h00000001, 32'h01000001},
    {8'h00, 32'h3B000001, 32'h00010001},
    {8'h00, 32'h3B3B0003, 32'h00000103},
    {8'h00, 32'h3B3B1707, 32'h00000001},
    {8'h00, 32'h09000001, 32'h0A000001},
    {8'h01, 32'h09000001, 32'h10000001},
    {8'h01, 32'h59592305, 32'h00000006},
    {8'h01, 32'h59120002, 32'h00130002}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      ref_tick = 1'b1; @(negedge clk);
      ref_tick = 1'b0; @(negedge clk);
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic set_time(input logic [31:0] t);
    wr(4'd2, t[31:24]); wr(4'd3, t[23:16]); wr(4'd4, t[15:8]); wr(4'd5, t[7:0]);
  endtask

  task automatic get_time(output logic [31:0] t);
    logic [7:0] b;
    rd(4'd2, b); t[31:24] = b;
    rd(4'd3, b); t[23:16] = b;
    rd(4'd4, b); t[15:8]  = b;
    rd(4'd5, b); t[7:0]   = b;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired before the end of the run");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0]  d;
    logic [31:0] t;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R11 reset state
    rd(4'd0, d); chk("R11 ctrl", {24'h0, d}, 32'h0);
    rd(4'd1, d); chk("R11 aen", {24'h0, d}, 32'h0);
    get_time(t); chk("R11 time", t, 32'h00000001);
    rd(4'd6, d); chk("R11 alarm sec", {24'h0, d}, 32'h0);

    // R6 reserved bits read zero
    wr(4'd1, 8'hFF); rd(4'd1, d); chk("R6 aen upper bits", {24'h0, d}, 32'h0F);

    // R1 R3 R4 rollover table
    for (int i = 0; i < 8; i++) begin
      wr(4'd0, {6'b0, VEC[i][64], 1'b1});
      set_time(VEC[i][63:32]);
      wr(4'd0, {6'b0, VEC[i][64], 1'b0});
      ticks(TPS);
      get_time(t);
      chk(VEC[i][64] ? "R4 bcd step" : "R3 R1 binary step", t, VEC[i][31:0]);
    end

    // R9 locked writes ignored
    wr(4'd0, 8'h01); set_time(32'h10000001); wr(4'd0, 8'h00);
    wr(4'd2, 8'h30); wr(4'd6, 8'h22);
    rd(4'd2, d); chk("R9 locked time write", {24'h0, d}, 32'h10);
    rd(4'd6, d); chk("R9 locked alarm write", {24'h0, d}, 32'h00);

    // R2 control write restarts prescaler
    ticks(3); wr(4'd0, 8'h00); ticks(3);
    rd(4'd2, d); chk("R2 no advance after resync", {24'h0, d}, 32'h10);
    ticks(1);
    rd(4'd2, d); chk("R2 advance after full period", {24'h0, d}, 32'h11);

    // R1 two seconds from eight ticks
    ticks(8);
    rd(4'd2, d); chk("R1 count of advances", {24'h0, d}, 32'h13);

    // R5 R8 R7 tick-driven alarm with interrupt
    wr(4'd0, 8'h01); set_time(32'h00000001); wr(4'd6, 8'h02); wr(4'd1, 8'h01);
    wr(4'd0, 8'h04);
    rd(4'd0, d); chk("R5 no match at lock", {24'h0, d}, 32'h04);
    ticks(TPS); chk("R5 no alarm before match", {31'h0, irq_o}, 32'h0);
    ticks(TPS); chk("R8 irq on alarm", {31'h0, irq_o}, 32'h1);
    rd(4'd0, d); chk("R5 flag set", {24'h0, d}, 32'h84);
    chk("R7 irq cleared by read", {31'h0, irq_o}, 32'h0);
    rd(4'd0, d); chk("R7 flag cleared by read", {24'h0, d}, 32'h04);

    // R8 interrupt disabled
    wr(4'd0, 8'h01); set_time(32'h01000001); wr(4'd0, 8'h00);
    ticks(TPS); chk("R8 irq masked", {31'h0, irq_o}, 32'h0);
    rd(4'd0, d); chk("R8 flag without irq", {24'h0, d}, 32'h80);

    // R5 no field enabled
    wr(4'd0, 8'h01); wr(4'd1, 8'h00); set_time(32'h01000001); wr(4'd0, 8'h00);
    ticks(TPS); rd(4'd0, d); chk("R5 none enabled", {24'h0, d}, 32'h00);

    // R5 two fields enabled
    wr(4'd0, 8'h01); wr(4'd1, 8'h03); wr(4'd6, 8'h01); wr(4'd7, 8'h05);
    set_time(32'h00040001); wr(4'd0, 8'h00);
    ticks(TPS); rd(4'd0, d); chk("R5 partial match", {24'h0, d}, 32'h00);
    wr(4'd0, 8'h01); set_time(32'h00050001); wr(4'd0, 8'h00);
    ticks(TPS); rd(4'd0, d); chk("R5 full match", {24'h0, d}, 32'h80);

    // R5 lock evaluation, R7 read colliding with new event
    wr(4'd0, 8'h05); set_time(32'h07000001); wr(4'd6, 8'h07); wr(4'd1, 8'h01);
    rd(4'd0, d); chk("R5 writes do not evaluate", {24'h0, d}, 32'h05);
    wr(4'd0, 8'h04);
    rd(4'd0, d); chk("R7 read sees old flag", {24'h0, d}, 32'h04);
    chk("R7 event wins over read", {31'h0, irq_o}, 32'h1);
    rd(4'd0, d); chk("R7 flag kept", {24'h0, d}, 32'h84);

    // R4 BCD set point compare
    wr(4'd0, 8'h03); set_time(32'h09000001); wr(4'd6, 8'h10); wr(4'd1, 8'h01);
    wr(4'd0, 8'h02);
    rd(4'd0, d); chk("R4 no match before", {24'h0, d}, 32'h02);
    ticks(TPS);
    rd(4'd2, d); chk("R4 bcd seconds", {24'h0, d}, 32'h10);
    rd(4'd0, d); chk("R4 bcd alarm", {24'h0, d}, 32'h82);

    // R10 wake status survives reset
    sleep_i = 1'b1;
    wr(4'd0, 8'h01); set_time(32'h07000001); wr(4'd6, 8'h07); wr(4'd1, 8'h01);
    wr(4'd0, 8'h00);
    @(negedge clk);
    sleep_i = 1'b0;
    rst = 1'b1; repeat (2) @(negedge clk); rst = 1'b0; @(negedge clk);
    rd(4'd0, d); chk("R10 wake kept over reset", {24'h0, d}, 32'h20);
    rd(4'd0, d); chk("R10 wake cleared by read", {24'h0, d}, 32'h00);
    get_time(t); chk("R11 time after reset", t, 32'h00000001);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule